// File: doc/BRIEF.md
# Store Write-Protection Guard

This block guards the write side of a small word-addressed data memory. It keeps one protection bit per word. A command port can set that bit (lock) or clear it (release). Every store that reaches the block is checked against the protection state. A store to an unlocked word goes on to the memory write port. A store to a locked word is dropped and raises a one-cycle exception pulse.

Releasing a word also clears its content. The release writes zero into the word in the same cycle that clears its protection bit. The memory array sits inside the block so that stored contents can be read back through a combinational read port.

Stores arrive on a valid/ready stream. `st_ready` is low in exactly those cycles that carry a release command, because the release uses the single memory write port in that cycle. In every other cycle `st_ready` is high. A store is taken only in a cycle where `st_valid` and `st_ready` are both high. A store held while `st_ready` is low has no effect and must be held by the sender. The command port is plain: a command is acted on in every cycle where `cmd_valid` is high. `cmd_op` is encoded as 0 for lock and 1 for release.

Top module: `store_guard`

## Requirements
- R1: After reset every protection bit is clear: `st_ready` is 1, `exc_o` and `mem_we` are 0 while idle, and a store to any address is written with no exception.
- R2: A store taken at a locked address drives `exc_o` high in that same cycle only; `exc_o` is 0 in every cycle without such a store.
- R3: A store to a locked address leaves the memory word unchanged, and `mem_we` stays 0 in that cycle.
- R4: A release command (`cmd_op`=1) clears the protection bit of `cmd_addr`, so later stores to that address are written.
- R5: A release command writes zero to `cmd_addr` in the same cycle (`mem_we`=1, `mem_wdata`=0, `mem_addr`=`cmd_addr`), and the word reads back as zero from the next cycle.
- R6: A store taken at an unlocked address drives `mem_we`=1, `mem_addr`=`st_addr`, `mem_wdata`=`st_data`, and the data reads back from the next cycle.
- R7: `st_ready` is 0 exactly in cycles with `cmd_valid`=1 and `cmd_op`=1. A store held in such a cycle writes nothing.
- R8: A lock command (`cmd_op`=0) protects `cmd_addr` from the next cycle on. A store to the same address in the same cycle as the lock is still written.
- R9: Locking an address that is already locked changes no memory word and no other protection bit. Releasing an address that is already free only zeroes that word.
- R10: In every cycle `mem_we` is 1 exactly when a release is issued or an unlocked store is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 1 | 0 = lock, 1 = release |
| cmd_addr | input | ADDR_W | Word address of the command |
| st_valid | input | 1 | Store present |
| st_ready | output | 1 | Store can be taken this cycle |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data |
| mem_we | output | 1 | Gated memory write enable |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| exc_o | output | 1 | Rejected-store exception pulse |
| rd_addr | input | ADDR_W | Read-back address |
| rd_data | output | DATA_W | Read-back data (combinational) |

## Verification
Some properties are checked by assertions on every cycle:
- a rejected store never coincides with a memory write;
- a release always drives a zero write to its own address;
- a taken unlocked store always reaches the write port unchanged;
- a lock or release sets or clears its protection bit by the next cycle.

Other behaviour only the bench scenarios can show:
- memory contents staying put across blocked stores, repeated locks and stalled stores;
- the store-then-lock ordering on one address;
- a reset that leaves every one of the sixteen words writable.

These scenarios sweep every address, and the bench predicts each result with its own array model.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic {
    OP_LOCK    = 1'b0,
    OP_RELEASE = 1'b1
  } wp_op_e;
endpackage

// File: rtl/wp_lock_map.sv
module wp_lock_map #(
  parameter int WORDS = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic          clr_en,
  input  logic [AW-1:0] cmd_addr,
  input  logic [AW-1:0] query_addr,
  output logic          query_hit
);
  logic [WORDS-1:0] locks;

  for (genvar g = 0; g < WORDS; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)
        locks[g] <= 1'b0;
      else if (set_en && cmd_addr == AW'(g))
        locks[g] <= 1'b1;
      else if (clr_en && cmd_addr == AW'(g))
        locks[g] <= 1'b0;
    end
  end

  assign query_hit = locks[query_addr];

  // R8
  lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> locks[$past(cmd_addr)]);

  // R4
  lock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !locks[$past(cmd_addr)]);
endmodule

// File: rtl/wp_write_mux.sv
module wp_write_mux #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          free_req,
  input  logic [AW-1:0] cmd_addr,
  input  logic          st_fire,
  input  logic          st_blocked,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [DW-1:0] wdata
);
  always_comb begin
    we    = free_req | (st_fire & ~st_blocked);
    waddr = free_req ? cmd_addr : st_addr;
    wdata = free_req ? '0 : st_data;
  end
endmodule

// File: rtl/wp_store_mem.sv
module wp_store_mem #(
  parameter int WORDS = 16,
  parameter int AW    = 4,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [WORDS];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/store_guard.sv
module store_guard #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              exc_o,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  import wp_pkg::*;

  localparam int WORDS = 1 << ADDR_W;

  logic free_req, lock_req, st_fire, hit;

  assign free_req = cmd_valid && (cmd_op == OP_RELEASE);
  assign lock_req = cmd_valid && (cmd_op == OP_LOCK);
  assign st_ready = !free_req;
  assign st_fire  = st_valid && st_ready;
  assign exc_o    = st_fire && hit;

  wp_lock_map #(.WORDS(WORDS), .AW(ADDR_W)) u_map (
    .clk(clk), .rst_n(rst_n), .set_en(lock_req), .clr_en(free_req),
    .cmd_addr(cmd_addr), .query_addr(st_addr), .query_hit(hit)
  );

  wp_write_mux #(.AW(ADDR_W), .DW(DATA_W)) u_mux (
    .free_req(free_req), .cmd_addr(cmd_addr), .st_fire(st_fire),
    .st_blocked(hit), .st_addr(st_addr), .st_data(st_data),
    .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata)
  );

  wp_store_mem #(.WORDS(WORDS), .AW(ADDR_W), .DW(DATA_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );

  // R3
  blocked_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_o |-> !mem_we);

  // R5
  free_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_req |-> (mem_we && mem_wdata == '0 && mem_addr == cmd_addr));

  // R6
  store_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready && !exc_o) |->
      (mem_we && mem_addr == st_addr && mem_wdata == st_data));

  // R7
  stall_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st_ready |-> (mem_we && mem_wdata == '0));
endmodule

// File: tb/test_store_guard.sv
`timescale 1ns/1ps
module test_store_guard;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_op = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic st_valid = 1'b0;
  logic st_ready;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic exc_o;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [DW-1:0] exp_mem [N];
  bit exp_lock [N];

  always #10 clk = ~clk;

  store_guard #(.ADDR_W(AW), .DATA_W(DW)) i_store_guard (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .exc_o(exc_o),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, check combinational outputs before posedge
  task automatic step(input bit cv, input bit op, input logic [AW-1:0] ca,
                      input bit sv, input logic [AW-1:0] sa, input logic [DW-1:0] sd);
    bit e_rdy, e_acc, e_exc, e_we;
    logic [AW-1:0] e_addr;
    logic [DW-1:0] e_data;
    @(negedge clk);
    cmd_valid = cv; cmd_op = op; cmd_addr = ca;
    st_valid = sv; st_addr = sa; st_data = sd;
    e_rdy = !(cv && op);
    e_acc = sv && e_rdy;
    e_exc = e_acc && exp_lock[sa];
    e_we  = (cv && op) || (e_acc && !exp_lock[sa]);
    e_addr = (cv && op) ? ca : sa;
    e_data = (cv && op) ? '0 : sd;
    #5;
    chk(st_ready == e_rdy, "R7 st_ready", 32'(st_ready), 32'(e_rdy));
    chk(exc_o == e_exc, "R2 exc_o", 32'(exc_o), 32'(e_exc));
    chk(mem_we == e_we, "R10 mem_we", 32'(mem_we), 32'(e_we));
    if (e_we) begin
      chk(mem_addr == e_addr, "R10 mem_addr", 32'(mem_addr), 32'(e_addr));
      chk(mem_wdata == e_data, "R10 mem_wdata", 32'(mem_wdata), 32'(e_data));
    end
    // store sees the old protection state (R8 ordering)
    if (e_acc && !exp_lock[sa]) exp_mem[sa] = sd;
    if (cv && op) begin exp_mem[ca] = '0; exp_lock[ca] = 1'b0; end
    if (cv && !op) exp_lock[ca] = 1'b1;
    @(posedge clk);
  endtask

  task automatic idle();
    step(1'b0, 1'b0, '0, 1'b0, '0, '0);
  endtask

  task automatic chk_all(input string tag);
    for (int a = 0; a < N; a++) begin
      @(negedge clk);
      cmd_valid = 1'b0; st_valid = 1'b0;
      rd_addr = AW'(a);
      #1;
      chk(rd_data == exp_mem[a], tag, 32'(rd_data), 32'(exp_mem[a]));
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < N; a++) begin exp_mem[a] = '0; exp_lock[a] = 1'b0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #5;
    // R1 reset state at the ports
    chk(st_ready == 1'b1, "R1 st_ready after reset", 32'(st_ready), 32'd1);
    chk(exc_o == 1'b0, "R1 exc_o after reset", 32'(exc_o), 32'd0);
    chk(mem_we == 1'b0, "R1 mem_we after reset", 32'(mem_we), 32'd0);

    // R1 R6: every address writable after reset
    for (int a = 0; a < N; a++)
      step(1'b0, 1'b0, '0, 1'b1, AW'(a), DW'(a * 16'h1111) ^ 16'h0F0F);
    chk_all("R6 store readback");

    // R8: lock even addresses
    for (int a = 0; a < N; a += 2) step(1'b1, 1'b0, AW'(a), 1'b0, '0, '0);
    // R2 R3: stores to locked words blocked, unlocked ones written
    for (int a = 0; a < N; a++)
      step(1'b0, 1'b0, '0, 1'b1, AW'(a), 16'hA000 | DW'(a));
    chk_all("R3 blocked store readback");

    // R9: relock word 2, then store to 2 still blocked, nothing else changes
    step(1'b1, 1'b0, AW'(2), 1'b0, '0, '0);
    step(1'b0, 1'b0, '0, 1'b1, AW'(2), 16'h5555);
    chk_all("R9 relock no side effect");

    // R5 R4: release word 4 zeroes it, then a store goes through
    step(1'b1, 1'b1, AW'(4), 1'b0, '0, '0);
    chk_all("R5 release zeroes word");
    step(1'b0, 1'b0, '0, 1'b1, AW'(4), 16'hBEEF);
    chk_all("R4 store after release");

    // R9: release an already free word only zeroes it
    step(1'b1, 1'b1, AW'(5), 1'b0, '0, '0);
    chk_all("R9 release of free word");

    // R7: release with a held store; store writes nothing until ready
    step(1'b1, 1'b1, AW'(9), 1'b1, AW'(7), 16'h7777);
    chk_all("R7 stalled store no effect");
    step(1'b0, 1'b0, '0, 1'b1, AW'(7), 16'h7777);
    chk_all("R7 store after stall");

    // R8: store and lock on one address in one cycle, store completes
    step(1'b1, 1'b0, AW'(1), 1'b1, AW'(1), 16'h1234);
    step(1'b0, 1'b0, '0, 1'b1, AW'(1), 16'hDEAD);
    chk_all("R8 store before lock");

    // R4: release every word, then every store passes
    for (int a = 0; a < N; a++) step(1'b1, 1'b1, AW'(a), 1'b0, '0, '0);
    for (int a = 0; a < N; a++)
      step(1'b0, 1'b0, '0, 1'b1, AW'(a), 16'hC000 + DW'(a));
    idle();
    chk_all("R4 all free after release");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule